// File: doc/BRIEF.md
# Carry-Completion Sensing Adder

This block adds two unsigned words and a carry-in. It does not wait for a fixed worst-case carry delay. Every bit position holds a two-rail carry code that settles one step per clock cycle. The rail pair records a carry known to be one, a carry known to be zero, or a carry not yet known. A bit whose operand bits are equal settles on the first step. A bit whose operand bits differ takes over the code of the bit below it. The operation ends as soon as every position has settled, so the number of cycles depends on the longest run of differing operand bits.

A caller pulses `start_i` with the operands present. The block then runs on its own and raises `done_o`, together with a registered sum and carry-out. `done_o` stays high, and the results stay unchanged, until the next accepted start. The carry-in is handled as one extra position below bit 0. It settles on the first step like any bit with equal operand bits.

Top module: `ccs_adder`

## Requirements
- R1: After reset, `done_o` is 0, `sum_o` is 0 and `cout_o` is 0.
- R2: A `start_i` sampled high while no addition is running captures `a_i`, `b_i` and `cin_i` and clears every rail pair to (C,N)=(0,0). `done_o` is 0 after that edge.
- R3: On each step, a position whose operand bits are both 0 takes the pair (C,N)=(0,1), meaning a carry of 0.
- R4: On each step, a position whose operand bits are both 1 takes the pair (C,N)=(1,0), meaning a carry of 1.
- R5: On each step, a position whose operand bits differ copies the pair that the position directly below it held before the step.
- R6: The carry-in is a position below bit 0 whose operand bits both equal `cin_i`. Its pair is the carry into bit 0.
- R7: No position ever holds C=1 and N=1 together.
- R8: `done_o` rises on the clock edge at which every position first holds C=1 or N=1. This is exactly L+1 edges after the accepting edge, where L is the longest run of adjacent bit positions with a_i[k] != b_i[k] (L=0 when there is none).
- R9: When `done_o` rises, {`cout_o`,`sum_o`} equals a+b+cin for the captured operands. Sum bit k is a[k]^b[k]^(carry into k), and `cout_o` is the carry out of the top bit.
- R10: Once high, `done_o`, `sum_o` and `cout_o` hold their values until the next accepted start, whatever the operand inputs do.
- R11: While an addition is running, `start_i` and changes on `a_i`, `b_i` and `cin_i` have no effect on the result or its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe; operands sampled on the same edge |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry-in |
| done_o | output | 1 | Result valid level, held until the next accepted start |
| sum_o | output | WIDTH | Sum |
| cout_o | output | 1 | Carry-out |

## Verification
Three kinds of directed operand pairs are used. Equal operands (all zero, all one) contain only killing or generating bits and must finish in one cycle. A differing bit with an even step between differences gives isolated runs of length one. A word whose bits all differ gives a run across the full width, the slowest case. Each of these tells a fixed-latency design apart from one that tracks completion. Runs placed at the bottom, the middle and the top of the word separate correct carry-in handling from an off-by-one at either end. Random operands then test the sum against the arithmetic result and the cycle count against the longest differing run computed in the bench. Further runs restart the block while it is busy or after it has finished, to show which starts it ignores.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } ccs_state_e;

  // dual-rail carry code: c=1 carry one, n=1 carry zero, both 0 unknown
  typedef struct packed {
    logic c;
    logic n;
  } ccs_pair_t;
endpackage

// File: rtl/ccs_cell.sv
module ccs_cell
  import ccs_pkg::*;
(
  input  logic      a_i,
  input  logic      b_i,
  input  ccs_pair_t low_i,
  output ccs_pair_t nxt_o
);
  always_comb begin
    unique case ({a_i, b_i})
      2'b00:   nxt_o = '{c: 1'b0, n: 1'b1};
      2'b11:   nxt_o = '{c: 1'b1, n: 1'b0};
      default: nxt_o = low_i;
    endcase
  end
endmodule

// File: rtl/ccs_carry_net.sv
module ccs_carry_net
  import ccs_pkg::*;
#(
  parameter int unsigned WIDTH = 15,
  localparam int unsigned POS = WIDTH + 1
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  input  logic [POS-1:0]   c_i,
  input  logic [POS-1:0]   n_i,
  output logic [POS-1:0]   c_o,
  output logic [POS-1:0]   n_o,
  output logic             all_res_o
);
  // position 0 is the carry-in, position k+1 is bit k
  logic [POS-1:0] pa, pb;
  assign pa = {a_i, cin_i};
  assign pb = {b_i, cin_i};

  for (genvar k = 0; k < POS; k++) begin : g_pos
    ccs_pair_t low, nxt;
    if (k == 0) begin : g_base
      assign low = '{c: 1'b0, n: 1'b0};
    end else begin : g_chain
      assign low = '{c: c_i[k-1], n: n_i[k-1]};
    end
    ccs_cell u_cell (
      .a_i  (pa[k]),
      .b_i  (pb[k]),
      .low_i(low),
      .nxt_o(nxt)
    );
    assign c_o[k] = nxt.c;
    assign n_o[k] = nxt.n;
  end

  assign all_res_o = &(c_o | n_o);
endmodule

// File: rtl/ccs_ctrl.sv
module ccs_ctrl
  import ccs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic all_res_i,
  output logic load_o,
  output logic step_o,
  output logic finish_o,
  output logic busy_o,
  output logic done_o
);
  ccs_state_e state_q, state_d;

  assign busy_o   = (state_q == ST_RUN);
  assign done_o   = (state_q == ST_DONE);
  assign load_o   = start_i && !busy_o;
  assign step_o   = busy_o;
  assign finish_o = busy_o && all_res_i;

  always_comb begin
    state_d = state_q;
    if (load_o)        state_d = ST_RUN;
    else if (finish_o) state_d = ST_DONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/ccs_adder.sv
module ccs_adder
  import ccs_pkg::*;
#(
  parameter int unsigned WIDTH = 15,
  localparam int unsigned POS = WIDTH + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic             done_o,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  logic [WIDTH-1:0] op_a_q, op_b_q, sum_q;
  logic             op_cin_q, cout_q;
  logic [POS-1:0]   c_q, n_q, c_d, n_d;
  logic             all_res, load, step, finish, busy;

  ccs_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .all_res_i(all_res),
    .load_o   (load),
    .step_o   (step),
    .finish_o (finish),
    .busy_o   (busy),
    .done_o   (done_o)
  );

  ccs_carry_net #(.WIDTH(WIDTH)) u_net (
    .a_i      (op_a_q),
    .b_i      (op_b_q),
    .cin_i    (op_cin_q),
    .c_i      (c_q),
    .n_i      (n_q),
    .c_o      (c_d),
    .n_o      (n_d),
    .all_res_o(all_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_a_q   <= '0;
      op_b_q   <= '0;
      op_cin_q <= 1'b0;
      c_q      <= '0;
      n_q      <= '0;
    end else if (load) begin
      op_a_q   <= a_i;
      op_b_q   <= b_i;
      op_cin_q <= cin_i;
      c_q      <= '0;
      n_q      <= '0;
    end else if (step) begin
      c_q <= c_d;
      n_q <= n_d;
    end
  end

  // carry into bit k sits at position k
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q  <= '0;
      cout_q <= 1'b0;
    end else if (finish) begin
      sum_q  <= op_a_q ^ op_b_q ^ c_d[WIDTH-1:0];
      cout_q <= c_d[WIDTH];
    end
  end

  assign sum_o  = sum_q;
  assign cout_o = cout_q;
endmodule

// File: rtl/ccs_adder_chk.sv
module ccs_adder_chk #(
  parameter int unsigned WIDTH = 15,
  localparam int unsigned POS = WIDTH + 1,
  localparam int unsigned CW  = $clog2(POS + 1) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             done_o,
  input logic [WIDTH-1:0] sum_o,
  input logic             cout_o,
  input logic             busy,
  input logic [WIDTH-1:0] op_a_q,
  input logic [POS-1:0]   c_q,
  input logic [POS-1:0]   n_q
);
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + 1'b1;
    else           run_cnt <= '0;
  end

  p_start_clears_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && done_o |=> !done_o);

  p_no_both_rails_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_q & n_q) == '0);

  p_settled_stays_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && $past(busy) |-> (((c_q | n_q) & $past(c_q | n_q)) == $past(c_q | n_q)));

  p_done_all_settled_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> &(c_q | n_q));

  p_bounded_run_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> run_cnt <= CW'(WIDTH));

  p_result_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o && $stable(sum_o) && $stable(cout_o));

  p_busy_ignores_inputs_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(op_a_q));
endmodule

bind ccs_adder ccs_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .done_o (done_o),
  .sum_o  (sum_o),
  .cout_o (cout_o),
  .busy   (busy),
  .op_a_q (op_a_q),
  .c_q    (c_q),
  .n_q    (n_q)
);

// File: tb/ccs_adder_tb_top.sv
module ccs_adder_tb_top;
  localparam int W = 15;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic         cin = 1'b0;
  logic         done;
  logic [W-1:0] sum;
  logic         cout;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ccs_adder #(.WIDTH(W)) dut_i (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .start_i(start),
    .a_i    (a),
    .b_i    (b),
    .cin_i  (cin),
    .done_o (done),
    .sum_o  (sum),
    .cout_o (cout)
  );

  function automatic int longest_run(logic [W-1:0] x, logic [W-1:0] y);
    int best = 0;
    int cur = 0;
    for (int k = 0; k < W; k++) begin
      if (x[k] != y[k]) begin
        cur++;
        if (cur > best) best = cur;
      end else cur = 0;
    end
    return best;
  endfunction

  function automatic logic [W:0] ref_sum(logic [W-1:0] x, logic [W-1:0] y, logic c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // run one add; optional disturbance while busy at cycle dist_at
  task automatic run_add(logic [W-1:0] x, logic [W-1:0] y, logic c, string tag,
                         int dist_at = -1);
    int cnt = 0;
    logic [W:0] exp = ref_sum(x, y, c);
    int lat = longest_run(x, y) + 1;
    @(negedge clk);
    a = x; b = y; cin = c; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check({tag, " R2 done low after start"}, longint'(done), 0);
    do begin
      if (cnt == dist_at) begin
        a = ~x; b = x; cin = ~c; start = 1'b1;
      end
      @(posedge clk);
      cnt++;
      @(negedge clk);
      start = 1'b0;
    end while (!done && cnt < W + 4);
    check({tag, " R8 latency"}, cnt, lat);
    check({tag, " R9 sum"}, longint'({cout, sum}), longint'(exp));
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W:0] held;
    void'($urandom(32'd1357));
    #3;
    check("R1 done at reset", longint'(done), 0);
    check("R1 sum at reset", longint'({cout, sum}), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 done after reset", longint'(done), 0);

    // R3: all kill, R6 carry-in only
    run_add('0, '0, 1'b0, "kill R3");
    run_add('0, '0, 1'b1, "kill cin R6");
    // R4: all generate
    run_add('1, '1, 1'b1, "gen R4");
    // R5: isolated differing bits, full-width run, runs at bottom/middle/top
    run_add(15'h5555, 15'h0000, 1'b1, "alt R5");
    run_add(15'h7FFF, 15'h0000, 1'b1, "fullprop R5");
    run_add(15'h7FFF, 15'h0000, 1'b0, "fullprop cin0 R6");
    run_add(15'h000F, 15'h0000, 1'b1, "low run R6");
    run_add(15'h03F0, 15'h0008, 1'b0, "mid run R5");
    run_add(15'h7C00, 15'h0200, 1'b0, "top run R5");

    // R11: restart and operand change mid-run are ignored
    run_add(15'h7FFF, 15'h0000, 1'b1, "busy start R11", 3);
    run_add(15'h1234, 15'h0FED, 1'b0, "busy start R11", 0);

    // R10: results hold while inputs change, no start
    held = {cout, sum};
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      a = W'($urandom); b = W'($urandom); cin = 1'($urandom);
    end
    @(negedge clk);
    check("R10 done held", longint'(done), 1);
    check("R10 result held", longint'({cout, sum}), longint'(held));

    for (int k = 0; k < 300; k++) begin
      logic [W-1:0] x = W'($urandom);
      logic [W-1:0] y = W'($urandom);
      logic c = 1'($urandom);
      if (k % 5 == 0) y = ~x;
      run_add(x, y, c, "rand R9");
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule